// File: doc/BRIEF.md
# Processor bus data-phase controller

This block runs the data phase of an external bus cycle for a processor on a 64-bit data bus. The core side asks for a cycle with a start request, a single-or-burst selector, a direction and a byte-enable mask. The controller then drives the address strobe for one clock and counts the ready handshakes the system returns. A single transfer takes one ready and a burst takes four. Every clock in which an expected ready is missing is a wait state, and nothing moves during a wait state.

Each clock the controller decides whether the ready input counts. It applies a fixed priority. Backoff beats ready and aborts the cycle. Init and a granted hold also mask ready. Address hold masks ready unless the cycle had already begun before address hold was raised. On reads, an accepted ready latches only the byte lanes, with their parity bits, that the cycle enables. On writes, the data and parity on the bus stay put until a ready accepts them. A cycle cut short by backoff is reissued from its first beat once backoff is released. A hold request that arrives mid-cycle is granted only after the whole cycle ends.

Top module: `bus_data_phase_ctrl`

## Requirements
- R1: After reset, busy_o, ads_o, hlda_o, restart_o, d_oe_o and rdata_o are all zero. A start_i sampled while idle, with no hold, backoff or init present, makes ads_o high for exactly the next clock. busy_o is high from that clock until the cycle ends.
- R2: brdy_i counts only from the clock after ads_o. A ready seen in the ads_o clock is ignored. A cycle with burst_i=1 ends on its fourth accepted ready and a cycle with burst_i=0 ends on its first. beat_o flags each accepted ready in the same clock.
- R3: On a read cycle (write_i=0), an accepted ready copies d_i byte k (bits 8k+7..8k) into rdata_o and dp_i bit k into rpar_o bit k, but only for lanes where the latched be_i bit k is 1. Other lanes keep their value, and write cycles never change rdata_o.
- R4: On a write cycle, d_oe_o is high while busy. d_o and dp_o carry the beat selected by wsel_o (0 for the first beat, then n for beat n). They change only at an accepted ready.
- R5: If boff_i is high in a busy clock, no ready is accepted, the cycle ends at once, and restart_o rises. After boff_i falls, the same cycle is reissued with ads_o and restarts from beat 0.
- R6: A ready that coincides with hold_i is accepted. hlda_o rises on the clock after the last ready of the cycle and falls one clock after hold_i is removed. When idle, hold_i raises hlda_o on the next clock.
- R7: While ahold_i is high, ready is accepted only if ahold_i was low when the cycle was issued. A cycle issued under ahold_i waits until ahold_i falls.
- R8: brdy_i has no effect while idle or while hlda_o is high: beat_o stays 0 and rdata_o is unchanged.
- R9: wait_o is high in every data clock without an accepted ready, barring abort. During such a clock d_o and rdata_o do not change.
- R10: init_i masks ready, ends any cycle, and clears a pending restart.
- R11: No cycle is issued while hlda_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous init; aborts and masks ready |
| start_i | input | 1 | Core requests a new cycle |
| burst_i | input | 1 | 1 = four-beat burst, 0 = single transfer |
| write_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 8 | Byte-lane enables for the cycle |
| wdata_i | input | 64 | Write data for the beat named by wsel_o |
| wpar_i | input | 8 | Write parity for the beat named by wsel_o |
| wsel_o | output | 2 | Index of the write beat to supply next |
| busy_o | output | 1 | A cycle is in progress |
| beat_o | output | 1 | Ready accepted this clock |
| wait_o | output | 1 | Expected ready absent this clock |
| restart_o | output | 1 | Aborted cycle waits for reissue |
| rdata_o | output | 64 | Latched read data |
| rpar_o | output | 8 | Latched read parity |
| ads_o | output | 1 | Address strobe |
| d_o | output | 64 | Bus write data |
| dp_o | output | 8 | Bus write parity |
| d_oe_o | output | 1 | Bus data drive enable |
| d_i | input | 64 | Bus read data |
| dp_i | input | 8 | Bus read parity |
| brdy_i | input | 1 | Ready from system logic |
| boff_i | input | 1 | Backoff |
| hold_i | input | 1 | Bus hold request |
| ahold_i | input | 1 | Address hold |
| hlda_o | output | 1 | Hold acknowledge |

## Verification
The main sweep runs single and burst cycles in both directions. It uses five byte-enable masks and three per-beat wait-state patterns, so partial-lane latching is told apart from full-word latching and a miscounted beat is told apart from a late one. Directed sequences then put ready in the same clock as backoff, hold, init and address hold, and in the address-strobe clock. They also raise it while idle and while hold is granted, which separates each rule of the priority order. Backoff is applied both in the strobe clock and mid-burst to show that the reissued cycle restarts at beat 0 with beat-0 write data.

// File: rtl/bus_data_phase_ctrl.sv
module bus_data_phase_ctrl #(
  parameter int DW        = 64,
  parameter int BURST_LEN = 4,
  localparam int LANES    = DW / 8,
  localparam int CW       = $clog2(BURST_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             start_i,
  input  logic             burst_i,
  input  logic             write_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] wpar_i,
  output logic [CW-1:0]    wsel_o,
  output logic             busy_o,
  output logic             beat_o,
  output logic             wait_o,
  output logic             restart_o,
  output logic [DW-1:0]    rdata_o,
  output logic [LANES-1:0] rpar_o,
  output logic             ads_o,
  output logic [DW-1:0]    d_o,
  output logic [LANES-1:0] dp_o,
  output logic             d_oe_o,
  input  logic [DW-1:0]    d_i,
  input  logic [LANES-1:0] dp_i,
  input  logic             brdy_i,
  input  logic             boff_i,
  input  logic             hold_i,
  input  logic             ahold_i,
  output logic             hlda_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} st_t;

  st_t              st_q;
  logic [CW-1:0]    done_q;
  logic             burst_q, write_q, pre_ah_q, restart_q, hlda_q;
  logic [LANES-1:0] be_q, wpar_q, rpar_q;
  logic [DW-1:0]    wbuf_q, rdata_q;
  logic [DW-1:0]    rd_nxt;
  logic [LANES-1:0] rp_nxt;

  wire idle   = (st_q == ST_IDLE);
  wire ah_ok  = ~ahold_i | pre_ah_q;
  wire rdy_ok = (st_q == ST_DATA) & brdy_i & ~boff_i & ~init_i & ~hlda_q & ah_ok;
  wire last   = (done_q == (burst_q ? CW'(BURST_LEN - 1) : '0));
  wire fin    = rdy_ok & last;
  wire issue  = idle & ~boff_i & ~init_i & ~hold_i & ~hlda_q & (restart_q | start_i);

  always_comb begin
    rd_nxt = rdata_q;
    rp_nxt = rpar_q;
    for (int k = 0; k < LANES; k++) begin
      if (be_q[k]) begin
        rd_nxt[k*8 +: 8] = d_i[k*8 +: 8];
        rp_nxt[k]        = dp_i[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      done_q    <= '0;
      burst_q   <= 1'b0;
      write_q   <= 1'b0;
      be_q      <= '0;
      pre_ah_q  <= 1'b0;
      restart_q <= 1'b0;
      hlda_q    <= 1'b0;
      wbuf_q    <= '0;
      wpar_q    <= '0;
      rdata_q   <= '0;
      rpar_q    <= '0;
    end else begin
      hlda_q <= hold_i & (hlda_q | idle | fin);
      if (rdy_ok && !write_q) begin
        rdata_q <= rd_nxt;
        rpar_q  <= rp_nxt;
      end
      if (init_i) begin
        st_q      <= ST_IDLE;
        done_q    <= '0;
        restart_q <= 1'b0;
      end else if (idle) begin
        if (issue) begin
          st_q      <= ST_ADDR;
          done_q    <= '0;
          restart_q <= 1'b0;
          pre_ah_q  <= ~ahold_i;
          wbuf_q    <= wdata_i;
          wpar_q    <= wpar_i;
          if (!restart_q) begin
            burst_q <= burst_i;
            write_q <= write_i;
            be_q    <= be_i;
          end
        end
      end else if (boff_i) begin
        st_q      <= ST_IDLE;
        done_q    <= '0;
        restart_q <= 1'b1;
      end else if (st_q == ST_ADDR) begin
        st_q <= ST_DATA;
      end else if (rdy_ok) begin
        if (last) begin
          st_q   <= ST_IDLE;
          done_q <= '0;
        end else begin
          done_q <= done_q + CW'(1);
          wbuf_q <= wdata_i;
          wpar_q <= wpar_i;
        end
      end
    end
  end

  assign wsel_o    = idle ? '0 : done_q + CW'(1);
  assign busy_o    = ~idle;
  assign beat_o    = rdy_ok;
  assign wait_o    = (st_q == ST_DATA) & ~rdy_ok & ~boff_i & ~init_i;
  assign restart_o = restart_q;
  assign rdata_o   = rdata_q;
  assign rpar_o    = rpar_q;
  assign ads_o     = (st_q == ST_ADDR);
  assign d_o       = wbuf_q;
  assign dp_o      = wpar_q;
  assign d_oe_o    = ~idle & write_q;
  assign hlda_o    = hlda_q;

endmodule

// File: rtl/bus_data_phase_ctrl_chk.sv
module bus_data_phase_ctrl_chk #(
  parameter int DW    = 64,
  parameter int LANES = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_i,
  input logic          boff_i,
  input logic          hold_i,
  input logic          busy_o,
  input logic          beat_o,
  input logic          wait_o,
  input logic          ads_o,
  input logic          restart_o,
  input logic          hlda_o,
  input logic          d_oe_o,
  input logic [DW-1:0] d_o,
  input logic [DW-1:0] rdata_o
);

  AST_ADS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) ads_o |=> !ads_o); // R1
  AST_NO_BEAT_IN_ADS: assert property (@(posedge clk) disable iff (!rst_n) ads_o |-> !beat_o); // R2
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe_o && !beat_o && !boff_i && !init_i) |=> $stable(d_o)); // R4
  AST_BOFF_WINS: assert property (@(posedge clk) disable iff (!rst_n) boff_i |-> !beat_o); // R5
  AST_BOFF_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && boff_i && !init_i) |=> (restart_o && !busy_o)); // R5
  AST_HLDA_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(hlda_o) |-> $past(hold_i)); // R6
  AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !beat_o); // R8
  AST_WAIT_STILL: assert property (@(posedge clk) disable iff (!rst_n) wait_o |=> $stable(rdata_o)); // R9
  AST_INIT_MASKS: assert property (@(posedge clk) disable iff (!rst_n) init_i |-> !beat_o); // R10
  AST_HLDA_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) hlda_o |-> (!busy_o && !ads_o)); // R11

endmodule

bind bus_data_phase_ctrl bus_data_phase_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .init_i(init_i), .boff_i(boff_i), .hold_i(hold_i),
  .busy_o(busy_o), .beat_o(beat_o), .wait_o(wait_o), .ads_o(ads_o),
  .restart_o(restart_o), .hlda_o(hlda_o), .d_oe_o(d_oe_o), .d_o(d_o),
  .rdata_o(rdata_o)
);

// File: tb/bus_data_phase_ctrl_tb_top.sv
module bus_data_phase_ctrl_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, init_i, start_i, burst_i, write_i, brdy_i, boff_i, hold_i, ahold_i;
  logic [7:0]  be_i, wpar_i, rpar_o, dp_o, dp_i;
  logic [63:0] wdata_i, rdata_o, d_o, d_i;
  logic [1:0]  wsel_o;
  logic busy_o, beat_o, wait_o, restart_o, ads_o, d_oe_o, hlda_o;
  logic [7:0] wseed;

  bus_data_phase_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .start_i(start_i), .burst_i(burst_i),
    .write_i(write_i), .be_i(be_i), .wdata_i(wdata_i), .wpar_i(wpar_i), .wsel_o(wsel_o),
    .busy_o(busy_o), .beat_o(beat_o), .wait_o(wait_o), .restart_o(restart_o),
    .rdata_o(rdata_o), .rpar_o(rpar_o), .ads_o(ads_o), .d_o(d_o), .dp_o(dp_o),
    .d_oe_o(d_oe_o), .d_i(d_i), .dp_i(dp_i), .brdy_i(brdy_i), .boff_i(boff_i),
    .hold_i(hold_i), .ahold_i(ahold_i), .hlda_o(hlda_o)
  );

  function automatic logic [63:0] wpat(int i);
    return {8{8'(i * 29 + 5)}} ^ {8{wseed}};
  endfunction
  function automatic logic [7:0] wppar(int i);
    return 8'(i * 3 + 1) ^ wseed;
  endfunction
  function automatic logic [63:0] rpat(int s, int b);
    return 64'h0F1E2D3C4B5A6978 ^ {8{8'(b * 19 + 33)}} ^ (64'(s) << (8 * (s % 8)));
  endfunction
  function automatic logic [7:0] rppar(int s, int b);
    return 8'(b * 37 + s);
  endfunction

  always_comb begin
    wdata_i = wpat(int'(wsel_o));
    wpar_i  = wppar(int'(wsel_o));
  end

  int n_chk = 0, n_fail = 0;
  logic [63:0] exp_rd;
  logic [7:0]  exp_rp;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic beat_in(int s, int b, bit wr);
    d_i = rpat(s, b);
    dp_i = rppar(s, b);
    brdy_i = 1'b1;
    #1;
    if (!wr) begin
      for (int k = 0; k < 8; k++)
        if (be_i[k]) begin
          exp_rd[k*8 +: 8] = d_i[k*8 +: 8];
          exp_rp[k] = dp_i[k];
        end
    end
  endtask

  task automatic run_cycle(int s, bit bu, bit wr, logic [7:0] be, int wm);
    logic [63:0] snap_d, snap_r;
    int n;
    n = bu ? 4 : 1;
    wseed = 8'(s * 7);
    start_i = 1'b1; burst_i = bu; write_i = wr; be_i = be;
    step();
    chk("R1 ads after start", {ads_o, busy_o}, 2'b11);
    start_i = 1'b0;
    brdy_i = 1'b1;
    #1 chk("R2 ready in ads clock ignored", beat_o, 1'b0);
    step();
    chk("R1 ads one clock", ads_o, 1'b0);
    for (int b = 0; b < n; b++) begin
      for (int w = 0; w < (b + wm) % 3; w++) begin
        brdy_i = 1'b0;
        #1 chk("R9 wait flagged", wait_o, 1'b1);
        snap_d = d_o; snap_r = rdata_o;
        step();
        chk("R9 d_o still in wait", d_o, snap_d);
        chk("R9 rdata still in wait", rdata_o, snap_r);
      end
      beat_in(s, b, wr);
      chk("R2 ready accepted", {beat_o, wait_o}, 2'b10);
      if (wr) begin
        chk("R4 write data beat", d_o, wpat(b));
        chk("R4 write parity beat", {d_oe_o, dp_o}, {1'b1, wppar(b)});
      end
      step();
      brdy_i = 1'b0;
      chk("R3 read lanes", rdata_o, exp_rd);
      chk("R3 read parity lanes", rpar_o, exp_rp);
      chk("R2 beat count", busy_o, (b < n - 1));
    end
    brdy_i = 1'b1;
    #1 chk("R8 idle ready ignored", beat_o, 1'b0);
    step();
    brdy_i = 1'b0;
    chk("R8 idle rdata kept", rdata_o, exp_rd);
    be_i = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    automatic int s = 0;
    logic [7:0] bes [5];
    rst_n = 0; init_i = 0; start_i = 0; burst_i = 0; write_i = 0; be_i = 0;
    brdy_i = 0; boff_i = 0; hold_i = 0; ahold_i = 0; d_i = 0; dp_i = 0; wseed = 0;
    exp_rd = '0; exp_rp = '0;
    bes[0] = 8'hFF; bes[1] = 8'h0F; bes[2] = 8'hA5; bes[3] = 8'h80; bes[4] = 8'h00;
    step(); step();
    chk("R1 reset state", {busy_o, ads_o, hlda_o, restart_o, d_oe_o}, 5'b0);
    chk("R1 reset rdata", rdata_o, 64'h0);
    rst_n = 1;
    step();

    for (int bu = 0; bu < 2; bu++)
      for (int wr = 0; wr < 2; wr++)
        for (int e = 0; e < 5; e++)
          for (int wm = 0; wm < 3; wm++) begin
            s++;
            run_cycle(s, bu[0], wr[0], bes[e], wm);
          end

    // R5: backoff mid-burst read, then reissue from beat 0
    s++; be_i = 8'hFF; burst_i = 1; write_i = 0; start_i = 1;
    step(); start_i = 0; step();
    beat_in(s, 0, 0); step();
    beat_in(s, 1, 0); boff_i = 1;
    #1 chk("R5 backoff beats ready", beat_o, 1'b0);
    step(); brdy_i = 0;
    chk("R5 abort to idle with restart", {busy_o, restart_o}, 2'b01);
    step();
    chk("R5 no reissue during backoff", ads_o, 1'b0);
    boff_i = 0; step();
    chk("R5 reissue strobe", {ads_o, restart_o}, 2'b10);
    step();
    for (int b = 0; b < 4; b++) begin
      beat_in(s, b, 0); step(); brdy_i = 0;
      chk("R5 reissued cycle counts four", busy_o, (b < 3));
    end
    chk("R5 reissued read data", rdata_o, exp_rd);

    // R5: backoff on a write burst, reissue restores beat 0 data
    s++; wseed = 8'h5A; be_i = 8'hFF; burst_i = 1; write_i = 1; start_i = 1;
    step(); start_i = 0; step();
    beat_in(s, 0, 1); step();
    beat_in(s, 1, 1); step(); brdy_i = 0;
    chk("R4 write beat two staged", d_o, wpat(2));
    boff_i = 1; step(); boff_i = 0;
    chk("R5 write abort", {busy_o, restart_o}, 2'b01);
    step();
    chk("R5 write reissue beat 0", {ads_o, d_o}, {1'b1, wpat(0)});
    step();
    for (int b = 0; b < 4; b++) begin beat_in(s, b, 1); step(); brdy_i = 0; end
    chk("R5 write reissue done", busy_o, 1'b0);

    // R5 and R10: backoff in ads clock, then init clears restart
    burst_i = 1; write_i = 0; start_i = 1;
    step(); start_i = 0; boff_i = 1; step();
    chk("R5 abort in ads clock", {busy_o, restart_o}, 2'b01);
    boff_i = 0; init_i = 1; step();
    chk("R10 init clears restart", {restart_o, ads_o}, 2'b00);
    init_i = 0; step();
    chk("R10 no reissue after init", {ads_o, busy_o}, 2'b00);

    // R10: init masks ready and ends the cycle
    s++; be_i = 8'hFF; burst_i = 1; start_i = 1;
    step(); start_i = 0; step();
    brdy_i = 1; init_i = 1;
    #1 chk("R10 init masks ready", beat_o, 1'b0);
    step(); init_i = 0; brdy_i = 0;
    chk("R10 init ends cycle", busy_o, 1'b0);

    // R6 and R11: hold coincident with ready mid-burst
    s++; be_i = 8'hFF; burst_i = 1; start_i = 1;
    step(); start_i = 0; step();
    beat_in(s, 0, 0); hold_i = 1;
    #1 chk("R6 ready taken with hold", beat_o, 1'b1);
    step();
    chk("R6 hold deferred", hlda_o, 1'b0);
    for (int b = 1; b < 4; b++) begin
      beat_in(s, b, 0); step(); brdy_i = 0;
      chk("R6 hlda after cycle end", {busy_o, hlda_o}, {b < 3, b == 3});
    end
    start_i = 1; burst_i = 0; brdy_i = 1;
    #1 chk("R8 ready ignored under hlda", beat_o, 1'b0);
    step(); brdy_i = 0;
    chk("R11 no strobe under hlda", {ads_o, hlda_o}, 2'b01);
    hold_i = 0; step();
    chk("R6 hlda falls one clock later", {hlda_o, ads_o}, 2'b00);
    step();
    chk("R11 start after release", ads_o, 1'b1);
    start_i = 0; step();
    beat_in(s, 0, 0); step(); brdy_i = 0;
    chk("R6 single after hold", busy_o, 1'b0);
    hold_i = 1; step();
    chk("R6 idle hold grant", hlda_o, 1'b1);
    hold_i = 0; step();
    chk("R6 idle hold release", hlda_o, 1'b0);

    // R7: address hold raised after issue lets ready through
    s++; burst_i = 0; start_i = 1;
    step(); start_i = 0; ahold_i = 1; step();
    beat_in(s, 0, 0);
    #1 chk("R7 prior cycle completes", beat_o, 1'b1);
    step(); brdy_i = 0;
    chk("R7 prior cycle done", busy_o, 1'b0);
    // R7: cycle issued under address hold waits for it to drop
    s++; start_i = 1;
    step(); start_i = 0; step();
    beat_in(s, 0, 0);
    chk("R7 ready masked under ahold", {beat_o, wait_o}, 2'b01);
    step();
    ahold_i = 0;
    #1 chk("R7 ready after ahold drop", beat_o, 1'b1);
    step(); brdy_i = 0;
    chk("R7 cycle done", {busy_o, rdata_o}, {1'b0, exp_rd});

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule